// File: doc/BRIEF.md
# Coarse-Time Slot Packet Framer

This block turns a stream of detector hit records into packets grouped by time slot. Each 48-bit hit carries a 32-bit coarse timestamp in bits 47:16 and 16 non-time bits in bits 15:0. The upper 16 bits of the timestamp name the slot. A packet opens with a header word that carries the slot number. A run of 32-bit data words follows the header. The packet ends when a hit arrives for a different slot, when the packet reaches its word limit, or when the input has been quiet long enough.

A slot can span milliseconds and hold far more data than one packet can carry. In that case the block closes the packet and opens another one with the same slot header. Both sides use valid/ready handshakes, and the output flags the final word of every packet.

To find the final word, the block holds back one data word. That word leaves only when the next hit or the quiet timer shows whether it ends the packet. The state machine has four states:
- ST_IDLE: no packet is open.
- ST_HEAD: the header word is offered.
- ST_STREAM: the held word is offered alongside each new hit.
- ST_FLUSH: the held word is offered as the last word after a quiet period.

The transitions are:
- ST_IDLE to ST_HEAD when a hit is accepted.
- ST_HEAD to ST_STREAM when the header is taken.
- ST_STREAM to ST_HEAD when an accepted hit closes the packet.
- ST_STREAM stays in ST_STREAM on a continuing hit.
- ST_STREAM to ST_FLUSH when the quiet timer expires.
- ST_FLUSH to ST_IDLE when the last word is taken.

Top module: `tslot_framer`

## Requirements
- R1: After reset the block is in ST_IDLE with `out_valid` low. While no packet is open, `out_valid` stays low.
- R2: Every packet starts with one header word. The header holds the slot (hit bits 47:32) in bits 31:16, has bits 15:0 at zero, and has `out_last` low.
- R3: Each data word is hit bits 31:0, which is the lower 16 timestamp bits in 31:16 and the non-time bits in 15:0. Data words leave in the order the hits were accepted.
- R4: If an accepted hit's slot differs from the open packet's slot, the held word leaves with `out_last` high. A new header carrying the new slot follows it.
- R5: A packet carries at most MAX_WORDS data words. The word that reaches the limit leaves with `out_last` high. A following hit of the same slot starts a new packet that repeats the same header.
- R6: While a packet is open, `idle_limit` consecutive cycles with `in_valid` low flush the held word with `out_last` high. The block then returns to ST_IDLE.
- R7: Whenever `out_ready` is low, `in_ready` is low. No word is lost, duplicated or reordered under any pattern of backpressure.
- R8: A header word is never marked last, and it is always followed by at least one data word of its packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_limit | input | IDLE_W | Number of quiet input cycles before an open packet is flushed |
| in_valid | input | 1 | Hit record valid |
| in_ready | output | 1 | Hit record accepted when high with `in_valid` |
| in_hit | input | HIT_W | Hit record: coarse time in bits 47:16, non-time bits in 15:0 |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | OUT_W | Header or data word |
| out_last | output | 1 | Final word of the packet |

## Verification
The bench builds the framer with MAX_WORDS at 4 and drives `idle_limit` at 6. With these values a single slot of nine hits splits into three packets that all carry the same header, so the repeated-header path runs many times in a short run. Quiet gaps longer than six cycles exercise the flush path. Gaps of zero to two cycles must not close a packet. A randomized phase throttles `out_ready` while slots advance at random points, which places slot changes, limit closures and stalls in the same cycle.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HEAD,
        ST_STREAM,
        ST_FLUSH
    } tsf_state_e;

endpackage

// File: rtl/tsf_hit_split.sv
module tsf_hit_split #(
    parameter int HIT_W  = 48,
    parameter int TIME_W = 32,
    parameter int SLOT_W = 16
) (
    input  logic [HIT_W-1:0]        hit,
    output logic [SLOT_W-1:0]       slot,
    output logic [HIT_W-SLOT_W-1:0] word
);
    localparam int PAY_W = HIT_W - TIME_W;
    localparam int LOW_W = TIME_W - SLOT_W;

    logic [TIME_W-1:0] coarse;

    always_comb begin
        coarse = hit[HIT_W-1:PAY_W];
        slot   = coarse[TIME_W-1:LOW_W];
        word   = {coarse[LOW_W-1:0], hit[PAY_W-1:0]};
    end
endmodule

// File: rtl/tsf_word_counter.sv
module tsf_word_counter #(
    parameter int MAX_WORDS = 360,
    parameter int CNT_W     = $clog2(MAX_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_one,
    input  logic             incr,
    output logic [CNT_W-1:0] cnt,
    output logic             at_limit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_one) begin
            cnt <= CNT_W'(1);
        end else if (incr) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign at_limit = (cnt == CNT_W'(MAX_WORDS));
endmodule

// File: rtl/tsf_idle_timer.sv
module tsf_idle_timer #(
    parameter int IDLE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [IDLE_W-1:0] limit,
    output logic              expire
);
    logic [IDLE_W-1:0] quiet_q;
    logic [IDLE_W:0]   next_cnt;

    always_comb begin
        next_cnt = {1'b0, quiet_q} + (IDLE_W+1)'(1);
        expire   = run && (next_cnt >= {1'b0, limit});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_q <= '0;
        end else if (run && !expire) begin
            quiet_q <= next_cnt[IDLE_W-1:0];
        end else begin
            quiet_q <= '0;
        end
    end
endmodule

// File: rtl/tslot_framer.sv
module tslot_framer
    import tsf_pkg::*;
#(
    parameter int HIT_W     = 48,
    parameter int TIME_W    = 32,
    parameter int SLOT_W    = 16,
    parameter int OUT_W     = HIT_W - SLOT_W,
    parameter int MAX_WORDS = 360,
    parameter int IDLE_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDLE_W-1:0] idle_limit,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [HIT_W-1:0]  in_hit,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OUT_W-1:0]  out_data,
    output logic              out_last
);
    localparam int CNT_W = $clog2(MAX_WORDS + 1);
    localparam int PAD_W = OUT_W - SLOT_W;

    tsf_state_e        state_q;
    tsf_state_e        state_d;
    logic [SLOT_W-1:0] in_slot;
    logic [OUT_W-1:0]  in_word;
    logic [SLOT_W-1:0] cur_slot_q;
    logic [OUT_W-1:0]  pend_q;
    logic [CNT_W-1:0]  word_cnt;
    logic              at_limit;
    logic              fire_in;
    logic              close_pkt;
    logic              opens_pkt;
    logic              quiet_run;
    logic              quiet_expire;

    tsf_hit_split #(
        .HIT_W (HIT_W),
        .TIME_W(TIME_W),
        .SLOT_W(SLOT_W)
    ) u_split (
        .hit (in_hit),
        .slot(in_slot),
        .word(in_word)
    );

    tsf_word_counter #(
        .MAX_WORDS(MAX_WORDS),
        .CNT_W    (CNT_W)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_one(fire_in && opens_pkt),
        .incr    (fire_in && !opens_pkt),
        .cnt     (word_cnt),
        .at_limit(at_limit)
    );

    tsf_idle_timer #(
        .IDLE_W(IDLE_W)
    ) u_quiet (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (quiet_run),
        .limit (idle_limit),
        .expire(quiet_expire)
    );

    assign fire_in   = in_valid && in_ready;
    assign close_pkt = (in_slot != cur_slot_q) || at_limit;
    assign opens_pkt = (state_q == ST_IDLE) || close_pkt;
    assign quiet_run = (state_q == ST_STREAM) && !in_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fire_in) state_d = ST_HEAD;
            end
            ST_HEAD: begin
                if (out_ready) state_d = ST_STREAM;
            end
            ST_STREAM: begin
                if (fire_in) begin
                    state_d = close_pkt ? ST_HEAD : ST_STREAM;
                end else if (quiet_expire) begin
                    state_d = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                if (out_ready) state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = pend_q;
        out_last  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = out_ready;
            end
            ST_HEAD: begin
                out_valid = 1'b1;
                out_data  = {cur_slot_q, {PAD_W{1'b0}}};
            end
            ST_STREAM: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_last  = close_pkt;
            end
            ST_FLUSH: begin
                out_valid = 1'b1;
                out_last  = 1'b1;
            end
        endcase
    end

    // held word and open slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q     <= '0;
            cur_slot_q <= '0;
        end else if (fire_in) begin
            pend_q <= in_word;
            if (opens_pkt) cur_slot_q <= in_slot;
        end
    end
endmodule

// File: rtl/tslot_framer_sva.sv
module tslot_framer_sva
    import tsf_pkg::*;
#(
    parameter int SLOT_W    = 16,
    parameter int MAX_WORDS = 360,
    parameter int CNT_W     = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_last,
    input tsf_state_e        state,
    input logic [CNT_W-1:0]  cnt,
    input logic [SLOT_W-1:0] cur_slot,
    input logic [SLOT_W-1:0] in_slot
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !out_valid);

    p_head_offer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_HEAD |-> out_valid && !out_last && !in_ready);

    p_slot_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_STREAM && in_valid && in_slot != cur_slot |-> out_last);

    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(MAX_WORDS));

    p_limit_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_STREAM && in_valid && cnt == CNT_W'(MAX_WORDS) |-> out_last);

    p_flush_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FLUSH |-> out_valid && out_last);

    p_stall_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |-> !in_ready);

    p_head_then_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_HEAD && out_ready |=> state == ST_STREAM);
endmodule

bind tslot_framer tslot_framer_sva #(
    .SLOT_W   (SLOT_W),
    .MAX_WORDS(MAX_WORDS),
    .CNT_W    (CNT_W)
) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_last (out_last),
    .state    (state_q),
    .cnt      (word_cnt),
    .cur_slot (cur_slot_q),
    .in_slot  (in_slot)
);

// File: tb/tslot_framer_bench.sv
module tslot_framer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAXW       = 4;
    localparam int QUIET      = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] idle_limit = 16'(QUIET);
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [47:0] in_hit = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        out_last;

    always #(CLK_PERIOD/2) clk = ~clk;

    tslot_framer #(.MAX_WORDS(MAXW)) u_tslot_framer (
        .clk(clk), .rst_n(rst_n), .idle_limit(idle_limit),
        .in_valid(in_valid), .in_ready(in_ready), .in_hit(in_hit),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    int checks = 0;
    int fails  = 0;
    bit stall_mode = 1'b0;
    bit finished = 1'b0;

    // reference model state
    logic [32:0] exp_q[$];
    string       tag_q[$];
    bit          m_open = 1'b0;
    int          m_cnt = 0;
    logic [15:0] m_slot = '0;
    logic [31:0] m_pend = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push(input bit last, input logic [31:0] w, input string tag);
        exp_q.push_back({last, w});
        tag_q.push_back(tag);
    endtask

    task automatic model_hit(input logic [47:0] h);
        logic [15:0] s;
        s = h[47:32];
        if (m_open) begin
            if (s != m_slot) begin
                push(1'b1, m_pend, "R4"); m_open = 1'b0;
            end else if (m_cnt == MAXW) begin
                push(1'b1, m_pend, "R5"); m_open = 1'b0;
            end else begin
                push(1'b0, m_pend, "R3"); m_cnt++; m_pend = h[31:0];
            end
        end
        if (!m_open) begin
            push(1'b0, {s, 16'h0000}, "R2");
            m_open = 1'b1; m_cnt = 1; m_slot = s; m_pend = h[31:0];
        end
    endtask

    task automatic model_flush();
        if (m_open) begin
            push(1'b1, m_pend, "R6");
            m_open = 1'b0;
        end
    endtask

    task automatic send_hit(input logic [47:0] h);
        in_hit = h;
        in_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        model_hit(h);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic gap(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic long_gap();
        stall_mode = 1'b0;
        model_flush();
        gap(5 * QUIET + 10);
    endtask

    // output ready pattern
    initial begin
        forever begin
            @(posedge clk); #1;
            out_ready = stall_mode ? ($urandom % 4 != 0) : 1'b1;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            check(!(!out_ready && in_ready), "R7", "in_ready while stalled",
                  64'(in_ready), 64'(0));
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected output word",
                          64'({out_last, out_data}), 64'(0));
                end else begin
                    logic [32:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({out_last, out_data} == e, t, "output word",
                          64'({out_last, out_data}), 64'(e));
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] slot;
        gap(3);
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", 64'(out_valid), 64'(0));
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'(0));
        check(in_ready == out_ready, "R1", "in_ready when idle", 64'(in_ready), 64'(out_ready));
        @(posedge clk); #1;

        // R3: back-to-back hits within one slot
        for (int i = 0; i < 3; i++) send_hit({16'h0011, 16'(16'h0100 + i), 16'(16'hA000 + i)});
        // R4: slot change with short gaps that must not flush
        for (int i = 0; i < 2; i++) begin
            gap(2);
            send_hit({16'h0012, 16'(16'h0200 + i), 16'(16'hB000 + i)});
        end
        // R5: nine hits of one slot split at the limit
        for (int i = 0; i < 9; i++) send_hit({16'h0013, 16'(16'h0300 + i), 16'(16'hC000 + i)});
        // R6: quiet flush, then the same slot reopens with a header
        long_gap();
        @(negedge clk);
        check(out_valid == 1'b0, "R6", "quiet after flush", 64'(out_valid), 64'(0));
        @(posedge clk); #1;
        for (int i = 0; i < 2; i++) send_hit({16'h0013, 16'(16'h0400 + i), 16'(16'hD000 + i)});
        long_gap();

        // R7: random slots under random backpressure
        stall_mode = 1'b1;
        slot = 16'h0100;
        for (int i = 0; i < 120; i++) begin
            if ($urandom % 5 == 0) slot = slot + 16'h1;
            send_hit({slot, 16'($urandom), 16'($urandom)});
            gap($urandom % 3);
        end
        long_gap();

        for (int i = 0; i < 200; i++) begin
            if (exp_q.size() == 0) break;
            @(posedge clk); #1;
        end
        check(exp_q.size() == 0, "R7", "words left undelivered", 64'(exp_q.size()), 64'(0));
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "idle at end", 64'(out_valid), 64'(0));

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule